// File: doc/BRIEF.md
# Registered Command/Address Buffer with Delayed Parity Check

This block sits between a memory controller and the DRAM devices on a registered memory module. On every rising clock edge it captures the command/address bus, the chip selects, the clock-enable lines and the on-die-termination lines. It drives registered copies of them on the next cycle. Each command/address bit is fanned out to two identical registered outputs, an A side and a B side, so that two groups of DRAM loads can be driven.

A static mode input chooses how the chip selects are handled. In dual mode only the two low chip-select inputs are used, and each of them is registered onto both an A copy and a B copy. In quad mode all four chip-select inputs are registered one-to-one onto the four outputs.

Bus integrity is protected by even parity. When a cycle is selected, the XOR of all command/address bits from that cycle is compared with a parity bit that the controller presents one clock later. On a mismatch the active-low error flag drops. A small state machine keeps the flag low for a fixed number of cycles after the last mismatch.

The state machine has two states:
- `ERR_RELEASED`: the flag is high.
- `ERR_ASSERTED`: the flag is low, and a hold counter runs.

It has four transitions:
- RELEASED→ASSERTED on a mismatch.
- ASSERTED→ASSERTED on a new mismatch, which reloads the counter.
- ASSERTED→ASSERTED while the counter runs down.
- ASSERTED→RELEASED when the counter is spent and no mismatch is present.

Top module: `cmd_reg_buffer`

## Requirements
- R1: Each command/address output bit equals the matching `ca_in` bit captured at the previous rising edge.
- R2: The A-side and B-side command/address outputs always carry the same registered value.
- R3: `cke_out` and `odt_out` equal `cke_in` and `odt_in` captured at the previous rising edge.
- R4: With `cs_dual_mode` high, `cs_out_n[1:0]` and `cs_out_n[3:2]` both equal the registered `cs_in_n[1:0]`. The values on `cs_in_n[3:2]` have no effect on any output, including the error flag.
- R5: With `cs_dual_mode` low, `cs_out_n[3:0]` equals the registered `cs_in_n[3:0]` bit for bit.
- R6: A cycle is selected when any enabled active-low chip select is 0. For a selected cycle, if `par_in` at the following rising edge differs from the XOR of that cycle's `ca_in`, then `err_n` is 0 after that following edge.
- R7: A cycle with no enabled chip select low never causes `err_n` to fall, whatever the parity.
- R8: `cke_in`, `odt_in` and the chip selects do not enter the parity computation.
- R9: After the last mismatch, `err_n` stays 0 for exactly ERR_HOLD cycles (default 2) and then returns to 1. A mismatch arriving during the hold restarts the count.
- R10: While `rst` is high at a rising edge, the command/address, clock-enable and termination outputs become 0, `cs_out_n` becomes all ones, and `err_n` becomes 1. The cycle captured under reset is never checked for parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_dual_mode | input | 1 | 1 = two chip selects duplicated, 0 = four direct chip selects |
| ca_in | input | CA_W | Command/address inputs |
| cs_in_n | input | 4 | Active-low chip-select inputs |
| cke_in | input | CKE_W | Clock-enable inputs |
| odt_in | input | ODT_W | On-die-termination inputs |
| par_in | input | 1 | Even parity of the previous cycle's `ca_in` |
| ca_a_out | output | CA_W | Registered command/address, A side |
| ca_b_out | output | CA_W | Registered command/address, B side |
| cs_out_n | output | 4 | Registered chip selects |
| cke_out | output | CKE_W | Registered clock enables |
| odt_out | output | ODT_W | Registered termination controls |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The bench builds the block with CA_W=20 and ERR_HOLD=3. With a hold of three cycles, a counter value sits in the middle of the hold, so the extend-on-new-mismatch path can be hit at more than one point of the countdown rather than only at its last cycle. The narrower bus keeps every bit toggled often under random stimulus. Random cycles switch the mode input and the chip-select patterns, so that parity errors fall both on selected cycles and on cycles selected only by the ignored upper chip selects.

// File: rtl/cmdbuf_pkg.sv
`timescale 1ns/1ps
package cmdbuf_pkg;

    typedef enum logic [0:0] {
        ERR_RELEASED = 1'b0,
        ERR_ASSERTED = 1'b1
    } err_state_e;

    localparam int CS_LANES = 4;
    localparam int CS_HALF  = CS_LANES / 2;

endpackage

// File: rtl/cmdbuf_capture.sv
`timescale 1ns/1ps
module cmdbuf_capture
    import cmdbuf_pkg::*;
#(
    parameter int CA_W  = 22,
    parameter int CKE_W = 2,
    parameter int ODT_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_dual_mode,
    input  logic [CA_W-1:0]     ca_in,
    input  logic [CS_LANES-1:0] cs_in_n,
    input  logic [CKE_W-1:0]    cke_in,
    input  logic [ODT_W-1:0]    odt_in,
    output logic [CA_W-1:0]     ca_a_q,
    output logic [CA_W-1:0]     ca_b_q,
    output logic [CS_LANES-1:0] cs_q_n,
    output logic [CKE_W-1:0]    cke_q,
    output logic [ODT_W-1:0]    odt_q,
    output logic                sel_q,
    output logic                par_calc_q
);

    logic [CS_LANES-1:0] cs_mapped_n;
    logic [CS_LANES-1:0] cs_enable;
    logic                sel_now;

    // Chip-select routing: dual mode copies the low half into both halves.
    genvar g;
    generate
        for (g = 0; g < CS_LANES; g++) begin : g_cs_map
            if (g < CS_HALF) begin : g_low
                assign cs_mapped_n[g] = cs_in_n[g];
                assign cs_enable[g]   = 1'b1;
            end else begin : g_high
                assign cs_mapped_n[g] = cs_dual_mode ? cs_in_n[g-CS_HALF] : cs_in_n[g];
                assign cs_enable[g]   = ~cs_dual_mode;
            end
        end
    endgenerate

    assign sel_now = |(~cs_in_n & cs_enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            ca_a_q     <= '0;
            ca_b_q     <= '0;
            cs_q_n     <= '1;
            cke_q      <= '0;
            odt_q      <= '0;
            sel_q      <= 1'b0;
            par_calc_q <= 1'b0;
        end else begin
            ca_a_q     <= ca_in;
            ca_b_q     <= ca_in;
            cs_q_n     <= cs_mapped_n;
            cke_q      <= cke_in;
            odt_q      <= odt_in;
            sel_q      <= sel_now;
            par_calc_q <= ^ca_in;
        end
    end

    p_ca_follow_r1: assert property (@(posedge clk) !rst |=> ca_a_q == $past(ca_in))
        else $error("R1 capture mismatch");
    p_ab_equal_r2: assert property (@(posedge clk) disable iff (rst) !rst |=> ca_b_q == ca_a_q)
        else $error("R2 side copies differ");
    p_ctrl_follow_r3: assert property (@(posedge clk)
        !rst |=> (cke_q == $past(cke_in)) && (odt_q == $past(odt_in)))
        else $error("R3 control capture mismatch");
    p_dual_copy_r4: assert property (@(posedge clk)
        !rst && cs_dual_mode |=> cs_q_n[CS_LANES-1:CS_HALF] == cs_q_n[CS_HALF-1:0])
        else $error("R4 dual copies differ");
    p_quad_direct_r5: assert property (@(posedge clk)
        !rst && !cs_dual_mode |=> cs_q_n == $past(cs_in_n))
        else $error("R5 quad mapping wrong");
    p_reset_cs_r10: assert property (@(posedge clk) rst |=> (&cs_q_n) && !sel_q)
        else $error("R10 reset chip selects");

endmodule

// File: rtl/cmdbuf_parity_fsm.sv
`timescale 1ns/1ps
module cmdbuf_parity_fsm
    import cmdbuf_pkg::*;
#(
    parameter int ERR_HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_q,
    input  logic par_calc_q,
    input  logic par_in,
    output logic err_n
);

    localparam int CNT_W = (ERR_HOLD > 1) ? $clog2(ERR_HOLD) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(ERR_HOLD - 1);

    err_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             mismatch;

    assign mismatch = sel_q & (par_calc_q ^ par_in);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ERR_RELEASED: begin
                if (mismatch) begin
                    state_d = ERR_ASSERTED;
                    cnt_d   = RELOAD;
                end
            end
            ERR_ASSERTED: begin
                if (mismatch) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    state_d = ERR_RELEASED;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ERR_RELEASED;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ERR_RELEASED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        err_n = (state_q != ERR_ASSERTED);
    end

    p_mismatch_flags_r6: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> !err_n)
        else $error("R6 mismatch not flagged");
    p_unselected_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        err_n && !sel_q |=> err_n)
        else $error("R7 flag fell without select");
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        state_q == ERR_ASSERTED && cnt_q == '0 && !mismatch |=> err_n)
        else $error("R9 flag not released");
    p_reset_err_r10: assert property (@(posedge clk) rst |=> err_n)
        else $error("R10 flag not released by reset");

endmodule

// File: rtl/cmd_reg_buffer.sv
`timescale 1ns/1ps
module cmd_reg_buffer
    import cmdbuf_pkg::*;
#(
    parameter int CA_W     = 22,
    parameter int CKE_W    = 2,
    parameter int ODT_W    = 2,
    parameter int ERR_HOLD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_dual_mode,
    input  logic [CA_W-1:0]  ca_in,
    input  logic [3:0]       cs_in_n,
    input  logic [CKE_W-1:0] cke_in,
    input  logic [ODT_W-1:0] odt_in,
    input  logic             par_in,
    output logic [CA_W-1:0]  ca_a_out,
    output logic [CA_W-1:0]  ca_b_out,
    output logic [3:0]       cs_out_n,
    output logic [CKE_W-1:0] cke_out,
    output logic [ODT_W-1:0] odt_out,
    output logic             err_n
);

    logic sel_q;
    logic par_calc_q;

    cmdbuf_capture #(
        .CA_W  (CA_W),
        .CKE_W (CKE_W),
        .ODT_W (ODT_W)
    ) u_capture (
        .clk          (clk),
        .rst          (rst),
        .cs_dual_mode (cs_dual_mode),
        .ca_in        (ca_in),
        .cs_in_n      (cs_in_n),
        .cke_in       (cke_in),
        .odt_in       (odt_in),
        .ca_a_q       (ca_a_out),
        .ca_b_q       (ca_b_out),
        .cs_q_n       (cs_out_n),
        .cke_q        (cke_out),
        .odt_q        (odt_out),
        .sel_q        (sel_q),
        .par_calc_q   (par_calc_q)
    );

    cmdbuf_parity_fsm #(
        .ERR_HOLD (ERR_HOLD)
    ) u_parity (
        .clk        (clk),
        .rst        (rst),
        .sel_q      (sel_q),
        .par_calc_q (par_calc_q),
        .par_in     (par_in),
        .err_n      (err_n)
    );

    // R8: toggling only control nets on a selected cycle with matching
    // parity never raises an error on the next edge.
    p_ctrl_excluded_r8: assert property (@(posedge clk) disable iff (rst)
        err_n && !(sel_q && (par_calc_q != par_in)) |=> err_n)
        else $error("R8 flag fell without parity mismatch");

endmodule

// File: tb/cmd_reg_buffer_tb.sv
`timescale 1ns/1ps
module cmd_reg_buffer_tb;

    localparam int CA_W  = 20;
    localparam int CKE_W = 2;
    localparam int ODT_W = 2;
    localparam int HOLD  = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             cs_dual_mode;
    logic [CA_W-1:0]  ca_in;
    logic [3:0]       cs_in_n;
    logic [CKE_W-1:0] cke_in;
    logic [ODT_W-1:0] odt_in;
    logic             par_in;
    logic [CA_W-1:0]  ca_a_out, ca_b_out;
    logic [3:0]       cs_out_n;
    logic [CKE_W-1:0] cke_out;
    logic [ODT_W-1:0] odt_out;
    logic             err_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model state
    bit m_sel_prev = 0;
    bit m_par_prev = 0;
    int m_cnt      = 0;

    always #2.5 clk = ~clk;

    cmd_reg_buffer #(
        .CA_W(CA_W), .CKE_W(CKE_W), .ODT_W(ODT_W), .ERR_HOLD(HOLD)
    ) u_dut (
        .clk(clk), .rst(rst), .cs_dual_mode(cs_dual_mode), .ca_in(ca_in),
        .cs_in_n(cs_in_n), .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
        .ca_a_out(ca_a_out), .ca_b_out(ca_b_out), .cs_out_n(cs_out_n),
        .cke_out(cke_out), .odt_out(odt_out), .err_n(err_n)
    );

    function automatic logic [3:0] exp_cs(input logic dual, input logic [3:0] cs);
        return dual ? {cs[1:0], cs[1:0]} : cs;
    endfunction

    function automatic bit exp_sel(input logic dual, input logic [3:0] cs);
        return dual ? (cs[1:0] != 2'b11) : (cs != 4'b1111);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle's inputs, pass an edge, then compare at the falling edge.
    task automatic step(input logic r, input logic dual, input logic [CA_W-1:0] ca,
                        input logic [3:0] cs, input logic [CKE_W-1:0] ck,
                        input logic [ODT_W-1:0] od, input logic p);
        bit mm;
        rst = r; cs_dual_mode = dual; ca_in = ca; cs_in_n = cs;
        cke_in = ck; odt_in = od; par_in = p;
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            m_cnt = 0; m_sel_prev = 0; m_par_prev = 0;
            check(ca_a_out == '0 && ca_b_out == '0, "R10", 64'(ca_a_out), 64'h0);
            check(cs_out_n == 4'hF && cke_out == '0 && odt_out == '0, "R10",
                  64'({cs_out_n, cke_out, odt_out}), 64'({4'hF, 4'h0}));
        end else begin
            mm = m_sel_prev && (m_par_prev != p);
            if (mm) m_cnt = HOLD; else if (m_cnt > 0) m_cnt--;
            m_sel_prev = exp_sel(dual, cs);
            m_par_prev = ^ca;
            check(ca_a_out == ca, "R1", 64'(ca_a_out), 64'(ca));
            check(ca_b_out == ca_a_out, "R2", 64'(ca_b_out), 64'(ca_a_out));
            check(cke_out == ck && odt_out == od, "R3", 64'({cke_out, odt_out}), 64'({ck, od}));
            check(cs_out_n == exp_cs(dual, cs), dual ? "R4" : "R5",
                  64'(cs_out_n), 64'(exp_cs(dual, cs)));
        end
        check(err_n == (m_cnt == 0), "R6/R7/R9", 64'(err_n), 64'(m_cnt == 0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [CA_W-1:0] ca;
        void'($urandom(32'd4242));
        rst = 1; cs_dual_mode = 1; ca_in = '0; cs_in_n = '1;
        cke_in = '0; odt_in = '0; par_in = 0;
        // R10: reset state
        step(1, 1, 20'hABCDE, 4'h0, 2'b11, 2'b11, 1);
        step(1, 0, 20'h12345, 4'h0, 2'b11, 2'b11, 0);

        // R6/R9: single mismatch in dual mode, then good cycles
        ca = 20'h00007;                       // odd parity
        step(0, 1, ca, 4'b1110, 2'b01, 2'b10, 0);
        step(0, 1, '0, 4'b1111, 2'b00, 2'b00, 0); // wrong: expected 1
        for (int i = 0; i < 5; i++) step(0, 1, '0, 4'b1111, 2'b00, 2'b00, 0);

        // R4/R7: only ignored upper selects low in dual mode, bad parity -> no flag
        step(0, 1, 20'h00001, 4'b0011, 2'b11, 2'b11, 0);
        step(0, 1, '0, 4'b1111, 2'b00, 2'b00, 0);
        step(0, 1, '0, 4'b1111, 2'b00, 2'b00, 0);

        // R5/R6: quad mode, upper select counts
        step(0, 0, 20'h00001, 4'b0111, 2'b10, 2'b01, 0);
        step(0, 0, '0, 4'b1111, 2'b00, 2'b00, 0);

        // R9: extend during hold
        step(0, 0, 20'h00003, 4'b1011, 2'b00, 2'b00, 0);
        step(0, 0, 20'h00001, 4'b1101, 2'b00, 2'b00, 1); // mismatch for prev? prev xor=0, p=1
        step(0, 0, '0, 4'b1111, 2'b00, 2'b00, 0);        // mismatch: prev xor=1, p=0
        for (int i = 0; i < 5; i++) step(0, 0, '0, 4'b1111, 2'b00, 2'b00, 0);

        // R8: control nets toggling with correct parity never flag
        for (int i = 0; i < 6; i++)
            step(0, 1, 20'h00000, 4'b1100, 2'(i), 2'(i + 1), 0);

        // R10: reset during hold releases flag and drops pending check
        step(0, 1, 20'h00001, 4'b1110, 2'b00, 2'b00, 0);
        step(0, 1, 20'h00001, 4'b1110, 2'b00, 2'b00, 0);
        step(1, 1, 20'h00000, 4'b1111, 2'b00, 2'b00, 0);
        step(0, 1, 20'h00000, 4'b1111, 2'b00, 2'b00, 1);

        // constrained random: mostly correct parity, occasional flips
        for (int i = 0; i < 3000; i++) begin
            logic [CA_W-1:0] rca;
            logic [3:0] rcs;
            logic pgood;
            logic dual;
            rca = CA_W'($urandom);
            rcs = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom);
            dual = ($urandom_range(0, 99) < 50);
            pgood = m_par_prev;
            if ($urandom_range(0, 9) == 0) pgood = ~pgood;
            step(($urandom_range(0, 499) == 0), dual, rca, rcs,
                 CKE_W'($urandom), ODT_W'($urandom), pgood);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule